// File: doc/BRIEF.md
# Saturating I/Q Summing Junction

This block merges the data streams that feed one DAC output channel. It has three adders, and each one saturates to a lower and an upper bound that software can program. The first adder sums the in-phase samples of two slow oscillators. The second adder does the same for their quadrature samples. Both results go to the fast up-converter, which lies outside this block. The third adder builds the DAC sample. It always includes an offset value. It can also include this channel's in-phase up-converter output and the quadrature up-converter output of the partner channel, each under its own enable.

A narrow write port sets the six bound registers and the two enable bits. Each adder produces its result one clock after its operands arrive. The sum is formed wide enough that it never wraps, then clamped to the bounds that were in effect at that clock edge.

Top module: `iq_sum_junction`

## Requirements
- R1: While reset is high, all three outputs are 0. After reset, every bound pair spans the full signed W-bit range. The in-phase enable is 1 and the quadrature enable is 0, so the DAC sample equals the offset plus this channel's in-phase input.
- R2: One clock after its operands are presented, `duc_in_i` equals the sum of `osc1_i` and `osc2_i`, clamped to the in-phase bounds.
- R3: One clock after its operands are presented, `duc_in_q` equals the sum of `osc1_q` and `osc2_q`, clamped to the quadrature bounds.
- R4: One clock after its operands are presented, `dac_out` equals `offset`, plus `duc_i` when the in-phase enable is 1, plus `buddy_q` when the quadrature enable is 1, clamped to the output bounds.
- R5: A sum that lies outside the signed W-bit range saturates at the bound and never wraps around.
- R6: A write places `cfg_data` into a register selected by `cfg_addr`:
  - address 2 is the enable word: bit 0 is the in-phase enable and bit 1 is the quadrature enable;
  - addresses 4 and 5 are the in-phase lower and upper bounds;
  - addresses 6 and 7 are the quadrature lower and upper bounds;
  - addresses 8 and 9 are the output lower and upper bounds.
- R7: A write to address 3, or to any address outside 2 and 4..9, changes no register and no output.
- R8: When a lower bound is greater than its upper bound, that adder outputs the upper bound for every input.
- R9: A bound written at a clock edge is used by the adder from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_data | input | W | Configuration write data (signed for bounds) |
| osc1_i | input | W | In-phase sample of slow oscillator 1 |
| osc2_i | input | W | In-phase sample of slow oscillator 2 |
| osc1_q | input | W | Quadrature sample of slow oscillator 1 |
| osc2_q | input | W | Quadrature sample of slow oscillator 2 |
| duc_i | input | W | In-phase up-converter output of this channel |
| buddy_q | input | W | Quadrature up-converter output of the partner channel |
| offset | input | W | Offset spline sample |
| duc_in_i | output | W | Clamped in-phase sum to the up-converter |
| duc_in_q | output | W | Clamped quadrature sum to the up-converter |
| dac_out | output | W | Clamped DAC sample |

## Verification
The bench builds the block with W = 6, so each sample covers -32..31. This makes it possible to sweep every operand pair of both oscillator adders, once with the default bounds and once with narrowed bounds. Every enable setting of the output adder is swept with a stride over its three operands. Inverted bounds, ignored addresses and the exact clock at which a freshly written bound takes effect are each checked against values computed in the bench.

// File: rtl/iqsum_pkg.sv
package iqsum_pkg;

    localparam int unsigned CFG_AW = 4;
    localparam int unsigned NJ     = 3;

    // Junction indices; bound addresses are derived from them
    localparam int unsigned J_I   = 0;
    localparam int unsigned J_Q   = 1;
    localparam int unsigned J_OUT = 2;

    localparam logic [CFG_AW-1:0] ADR_ENABLE   = 4'd2;
    localparam logic [CFG_AW-1:0] ADR_LIM_BASE = 4'd4;

    typedef enum logic [1:0] {
        SEL_PASS = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_HIGH = 2'd2
    } clamp_sel_e;

    // Lower bound of junction j sits at base + 2j, upper bound one above
    function automatic logic [CFG_AW-1:0] lim_addr(input int unsigned j, input logic upper);
        return ADR_LIM_BASE + CFG_AW'(2 * j) + CFG_AW'(upper);
    endfunction

endpackage

// File: rtl/iqsum_cfg.sv
module iqsum_cfg
    import iqsum_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [W-1:0]            cfg_data,
    output logic                    i_en,
    output logic                    q_en,
    output logic [NJ-1:0][W-1:0]    lim_lo,
    output logic [NJ-1:0][W-1:0]    lim_hi
);
    localparam logic [W-1:0] FULL_LO = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] FULL_HI = {1'b0, {(W-1){1'b1}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < NJ; j++) begin
                lim_lo[j] <= FULL_LO;
                lim_hi[j] <= FULL_HI;
            end
        end else if (cfg_we) begin
            for (int j = 0; j < NJ; j++) begin
                if (cfg_addr == lim_addr(j, 1'b0)) lim_lo[j] <= cfg_data;
                if (cfg_addr == lim_addr(j, 1'b1)) lim_hi[j] <= cfg_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            i_en <= 1'b1;
            q_en <= 1'b0;
        end else if (cfg_we && cfg_addr == ADR_ENABLE) begin
            i_en <= cfg_data[0];
            q_en <= cfg_data[1];
        end
    end

endmodule

// File: rtl/iqsum_sat_add.sv
module iqsum_sat_add
    import iqsum_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0][W-1:0]  term,
    input  logic [N-1:0]         term_en,
    input  logic [W-1:0]         lim_lo,
    input  logic [W-1:0]         lim_hi,
    output logic [W-1:0]         sum_q
);
    // Growth of clog2(N) bits plus one guard bit keeps the raw sum exact
    localparam int SW = W + $clog2(N) + 1;

    logic signed [SW-1:0] acc;
    logic signed [SW-1:0] lo_x;
    logic signed [SW-1:0] hi_x;
    clamp_sel_e           sel;
    logic [W-1:0]         result;

    always_comb begin
        acc = '0;
        for (int k = 0; k < N; k++) begin
            if (term_en[k]) acc = acc + SW'($signed(term[k]));
        end
        lo_x = SW'($signed(lim_lo));
        hi_x = SW'($signed(lim_hi));

        // Inverted bounds resolve to the upper bound
        if (acc > hi_x || lo_x > hi_x) sel = SEL_HIGH;
        else if (acc < lo_x)           sel = SEL_LOW;
        else                           sel = SEL_PASS;

        unique case (sel)
            SEL_HIGH: result = lim_hi;
            SEL_LOW:  result = lim_lo;
            default:  result = acc[W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sum_q <= '0;
        else     sum_q <= result;
    end

endmodule

// File: rtl/iq_sum_junction.sv
module iq_sum_junction
    import iqsum_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [W-1:0]      cfg_data,
    input  logic [W-1:0]      osc1_i,
    input  logic [W-1:0]      osc2_i,
    input  logic [W-1:0]      osc1_q,
    input  logic [W-1:0]      osc2_q,
    input  logic [W-1:0]      duc_i,
    input  logic [W-1:0]      buddy_q,
    input  logic [W-1:0]      offset,
    output logic [W-1:0]      duc_in_i,
    output logic [W-1:0]      duc_in_q,
    output logic [W-1:0]      dac_out
);
    logic                 i_en;
    logic                 q_en;
    logic [NJ-1:0][W-1:0] lim_lo;
    logic [NJ-1:0][W-1:0] lim_hi;

    iqsum_cfg #(.W(W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .i_en     (i_en),
        .q_en     (q_en),
        .lim_lo   (lim_lo),
        .lim_hi   (lim_hi)
    );

    iqsum_sat_add #(.W(W), .N(2)) u_add_i (
        .clk     (clk),
        .rst     (rst),
        .term    ({osc2_i, osc1_i}),
        .term_en (2'b11),
        .lim_lo  (lim_lo[J_I]),
        .lim_hi  (lim_hi[J_I]),
        .sum_q   (duc_in_i)
    );

    iqsum_sat_add #(.W(W), .N(2)) u_add_q (
        .clk     (clk),
        .rst     (rst),
        .term    ({osc2_q, osc1_q}),
        .term_en (2'b11),
        .lim_lo  (lim_lo[J_Q]),
        .lim_hi  (lim_hi[J_Q]),
        .sum_q   (duc_in_q)
    );

    iqsum_sat_add #(.W(W), .N(3)) u_add_out (
        .clk     (clk),
        .rst     (rst),
        .term    ({buddy_q, duc_i, offset}),
        .term_en ({q_en, i_en, 1'b1}),
        .lim_lo  (lim_lo[J_OUT]),
        .lim_hi  (lim_hi[J_OUT]),
        .sum_q   (dac_out)
    );

endmodule

// File: rtl/iq_sum_junction_chk.sv
module iq_sum_junction_chk
    import iqsum_pkg::*;
#(
    parameter int W = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_we,
    input logic [CFG_AW-1:0]    cfg_addr,
    input logic [W-1:0]         cfg_data,
    input logic [W-1:0]         duc_in_i,
    input logic [W-1:0]         duc_in_q,
    input logic [W-1:0]         dac_out,
    input logic                 i_en,
    input logic                 q_en,
    input logic [NJ-1:0][W-1:0] lim_lo,
    input logic [NJ-1:0][W-1:0] lim_hi
);
    logic bad_addr;
    assign bad_addr = (cfg_addr < 4'd2) || (cfg_addr == 4'd3) || (cfg_addr > 4'd9);

    // R2 / R5: in-phase sum stays inside ordered bounds
    a_r2_i_in_bounds: assert property (@(posedge clk) disable iff (rst)
        ($signed($past(lim_lo[J_I])) <= $signed($past(lim_hi[J_I])))
        |-> ($signed(duc_in_i) >= $signed($past(lim_lo[J_I])) &&
             $signed(duc_in_i) <= $signed($past(lim_hi[J_I]))));

    // R3 / R5: quadrature sum stays inside ordered bounds
    a_r3_q_in_bounds: assert property (@(posedge clk) disable iff (rst)
        ($signed($past(lim_lo[J_Q])) <= $signed($past(lim_hi[J_Q])))
        |-> ($signed(duc_in_q) >= $signed($past(lim_lo[J_Q])) &&
             $signed(duc_in_q) <= $signed($past(lim_hi[J_Q]))));

    // R8: inverted output bounds force the upper bound
    a_r8_inverted_out: assert property (@(posedge clk) disable iff (rst)
        ($signed($past(lim_lo[J_OUT])) > $signed($past(lim_hi[J_OUT])))
        |-> (dac_out == $past(lim_hi[J_OUT])));

    // R6: enable word bit placement
    a_r6_enable_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == ADR_ENABLE)
        |=> (i_en == $past(cfg_data[0]) && q_en == $past(cfg_data[1])));

    // R7: unmapped addresses leave every register alone
    a_r7_ignored_addr: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && bad_addr)
        |=> ($stable(lim_lo) && $stable(lim_hi) && $stable(i_en) && $stable(q_en)));

    // R9: output upper bound is loaded at the write edge
    a_r9_out_hi_load: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 4'd9)
        |=> (lim_hi[J_OUT] == $past(cfg_data)));

endmodule

bind iq_sum_junction iq_sum_junction_chk #(.W(W)) u_chk (.*);

// File: tb/iq_sum_junction_tb.sv
module iq_sum_junction_tb;
    localparam int W    = 6;
    localparam int VMIN = -(1 << (W - 1));
    localparam int VMAX = (1 << (W - 1)) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_addr = '0;
    logic [W-1:0] cfg_data = '0;
    logic [W-1:0] osc1_i = '0, osc2_i = '0, osc1_q = '0, osc2_q = '0;
    logic [W-1:0] duc_i = '0, buddy_q = '0, offset = '0;
    logic [W-1:0] duc_in_i, duc_in_q, dac_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // shadow configuration
    int ilo = VMIN, ihi = VMAX, qlo = VMIN, qhi = VMAX, olo = VMIN, ohi = VMAX;
    int ien = 1, qen = 0;

    always #2 clk = ~clk;

    iq_sum_junction #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .osc1_i(osc1_i), .osc2_i(osc2_i), .osc1_q(osc1_q), .osc2_q(osc2_q),
        .duc_i(duc_i), .buddy_q(buddy_q), .offset(offset),
        .duc_in_i(duc_in_i), .duc_in_q(duc_in_q), .dac_out(dac_out)
    );

    function automatic int sx(input logic [W-1:0] v);
        return int'($signed(v));
    endfunction

    function automatic int clampf(input int s, input int lo, input int hi);
        if (lo > hi) return hi;
        if (s < lo)  return lo;
        if (s > hi)  return hi;
        return s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = 4'(a);
        cfg_data = W'(d);
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic apply(input int a1, input int a2, input int q1, input int q2,
                         input int di, input int bq, input int off);
        @(negedge clk);
        osc1_i = W'(a1); osc2_i = W'(a2);
        osc1_q = W'(q1); osc2_q = W'(q2);
        duc_i = W'(di); buddy_q = W'(bq); offset = W'(off);
        @(posedge clk);
        #1;
    endtask

    task automatic sweep_pairs(input string tag);
        for (int a = VMIN; a <= VMAX; a++) begin
            for (int b = VMIN; b <= VMAX; b++) begin
                int si, sq, so;
                apply(a, b, b, -a - 1, a, b, b / 2);
                si = a + b;
                sq = b - a - 1;
                so = b / 2 + ien * a + qen * b;
                check((si > VMAX || si < VMIN) ? "R5" : {"R2 ", tag}, sx(duc_in_i), clampf(si, ilo, ihi));
                check({"R3 ", tag}, sx(duc_in_q), clampf(sq, qlo, qhi));
                check({"R1/R4 ", tag}, sx(dac_out), clampf(so, olo, ohi));
            end
        end
    endtask

    task automatic sweep_out(input string req, input int step);
        for (int o = VMIN; o <= VMAX; o += step) begin
            for (int d = VMIN; d <= VMAX; d += step) begin
                for (int q = VMIN; q <= VMAX; q += step) begin
                    apply(0, 0, 0, 0, d, q, o);
                    check(req, sx(dac_out), clampf(o + ien * d + qen * q, olo, ohi));
                end
            end
        end
    endtask

    initial begin
        // R1: reset values
        repeat (4) @(posedge clk);
        #1;
        check("R1 reset i", sx(duc_in_i), 0);
        check("R1 reset q", sx(duc_in_q), 0);
        check("R1 reset dac", sx(dac_out), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1/R2/R3/R5: default bounds, exhaustive pairs
        sweep_pairs("default");

        // R6: narrowed bounds
        wr(4, -10); ilo = -10;
        wr(5, 12);  ihi = 12;
        wr(6, -5);  qlo = -5;
        wr(7, 20);  qhi = 20;
        wr(8, -20); olo = -20;
        wr(9, 17);  ohi = 17;
        sweep_pairs("R6 narrowed");

        // R7: unmapped addresses ignored
        wr(3, 3);
        wr(0, 3);
        wr(1, -1);
        wr(10, 3);
        wr(15, -2);
        sweep_out("R7", 9);
        apply(31, 31, 31, 31, 0, 0, 0);
        check("R7 i bound", sx(duc_in_i), 12);
        check("R7 q bound", sx(duc_in_q), 20);

        // R4: all enable combinations (bit0 in-phase, bit1 quadrature)
        for (int e = 0; e < 4; e++) begin
            wr(2, e);
            ien = e & 1;
            qen = (e >> 1) & 1;
            sweep_out("R4", 5);
        end

        // R8: inverted bounds
        wr(8, 10); olo = 10;
        wr(9, -3); ohi = -3;
        sweep_out("R8", 7);
        wr(4, 5);  ilo = 5;
        wr(5, -6); ihi = -6;
        apply(-32, -32, 0, 0, 0, 0, 0);
        check("R8 i low side", sx(duc_in_i), -6);
        apply(31, 31, 0, 0, 0, 0, 0);
        check("R8 i high side", sx(duc_in_i), -6);

        // R9: a bound takes effect at the edge after its write
        wr(4, VMIN); ilo = VMIN;
        wr(5, VMAX); ihi = VMAX;
        apply(31, 31, 0, 0, 0, 0, 0);
        check("R9 before", sx(duc_in_i), VMAX);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd5; cfg_data = W'(5);
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        check("R9 write edge uses old bound", sx(duc_in_i), VMAX);
        @(posedge clk);
        #1;
        check("R9 next edge uses new bound", sx(duc_in_i), 5);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule